// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Force Registers

This block collects fifteen interrupt lines, numbered 1 to 15, and turns them into a 4-bit request level for each of a few CPUs. Software programs it through a 32-bit word-access register bus. Line numbers are bit positions in every register, and bit 0 never carries an interrupt.

An incoming interrupt pulse lands in one of two places. It goes into the shared pending register, or, if the line is marked for fan-out, into every CPU's private force register. Each CPU has a mask, and a shared group-select register splits the lines into a high-priority group and a low-priority group. Each CPU's request level names the highest line in the group it is served from.

A CPU acknowledges an interrupt by number. The acknowledge removes that line from the pending register and from that CPU's force register. A single write to a force register can set some bits and clear others at the same time.

Top module: `mpic_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and every CPU's request level is 0.
- R2: Bit 0 and bits 31:16 of the group-select, pending, fan-out, mask and force registers always read zero, whatever value was written.
- R3: CPU c's active set is (pending OR force[c]) AND mask[c]. Its level is the index of the highest active line whose group-select bit is 1. If no such line exists, it is the index of the highest remaining active line. With no active line the level is 0. The level follows the registered state with no extra cycle.
- R4: A write to the force register of CPU c (byte offset 0x80+4c) sets the lines given in data bits 15:1 and clears the lines given in data bits 31:17 (line n at bit 16+n). When a line is named in both, it ends up cleared.
- R5: A write to offset 0x0C removes the written lines (data bits 15:1) from pending. The offset itself reads zero.
- R6: A write to offset 0x08 replaces CPU 0's force register with data bits 15:1. A read of offset 0x08 returns CPU 0's force register.
- R7: An interrupt pulse on line n sets pending bit n if fan-out bit n is clear. If fan-out bit n is set, the pulse sets bit n in every CPU's force register and leaves pending untouched.
- R8: An acknowledge of line n by CPU c clears pending bit n and force[c] bit n and leaves the other CPUs' force registers alone. An acknowledge of line 0 has no effect.
- R9: Offset 0x10 always reads zero, and writes to it change no register.
- R10: The per-CPU word at 0xC0+4c stores only data bits 3:0 and reads back zero above them.
- R11: Reads of unmapped offsets, or of per-CPU offsets for CPUs beyond NCPU, return zero. Writes to them change no register.
- R12: When an interrupt pulse and a clear write or acknowledge hit the same line in the same cycle, the line ends up set.
- R13: The register map uses byte offsets 0x00 group-select, 0x04 pending, 0x08 CPU 0 force alias, 0x0C clear, 0x10 status, 0x14 fan-out, 0x40+4c mask, 0x80+4c force and 0xC0+4c extended, inside a 256-byte window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte address; bits 1:0 are ignored |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_pulse | input | 16 | Interrupt pulses, bit n for line n; bit 0 is ignored |
| ack_valid | input | NCPU | Acknowledge strobe per CPU |
| ack_line | input | 4*NCPU | Acknowledged line number per CPU, CPU c in bits 4c+3:4c |
| cpu_level | output | 4*NCPU | Request level per CPU, CPU c in bits 4c+3:4c |

## Verification
The bench runs pseudo-random mixes of group-select, mask, fan-out, force, pulse and acknowledge traffic and checks both CPU levels against an arithmetic priority model, so a design that inverted the groups or picked the lowest line shows a wrong level. After each phase it sweeps all 64 words of the map; a bit 0 that is kept, a write to a missing CPU that aliases onto a real one, or a status word that latches would each show up there. Directed cycles combine a pulse with a clear or an acknowledge on the same line, where a design that lets the clear win loses the interrupt. The force set-and-clear overlap and line-0 acknowledges are covered the same way.

// File: rtl/mpic_pkg.sv
// Package: shared widths, types and register word indices for the interrupt
// controller. Assumes a fixed 16-bit line vector with line 0 unused.
package mpic_pkg;
    localparam int LINES   = 16;
    localparam int LVLW    = 4;
    localparam int EXTW    = 4;
    localparam int WORDW   = 6;
    localparam int IDXW    = 4;

    typedef logic [LINES-1:0] vec_t;

    localparam vec_t LINE_MASK = 16'hFFFE;

    // word indices (byte offset / 4) of the global registers
    localparam logic [WORDW-1:0] W_GRP   = 6'h00;
    localparam logic [WORDW-1:0] W_PEND  = 6'h01;
    localparam logic [WORDW-1:0] W_ALIAS = 6'h02;
    localparam logic [WORDW-1:0] W_CLR   = 6'h03;
    localparam logic [WORDW-1:0] W_STAT  = 6'h04;
    localparam logic [WORDW-1:0] W_FAN   = 6'h05;

    // banks selected by word index bits 5:4
    localparam logic [1:0] BANK_GLOBAL = 2'd0;
    localparam logic [1:0] BANK_MASK   = 2'd1;
    localparam logic [1:0] BANK_FORCE  = 2'd2;
    localparam logic [1:0] BANK_EXT    = 2'd3;
endpackage

// File: rtl/mpic_regs.sv
// Module: register state of the controller. Holds group-select, pending,
// fan-out and the per-CPU mask, force and extended words. Applies one bus
// write, the acknowledges and the interrupt pulses each cycle, in that order,
// so a new interrupt always wins over a clear on the same line.
// Assumes NCPU is between 1 and 4 and word-aligned single-cycle writes.
module mpic_regs
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WORDW-1:0]      wr_word,
    input  logic [31:0]           wr_data,
    input  vec_t                  irq_in,
    input  logic [NCPU-1:0]       ack_vld,
    input  logic [NCPU*LVLW-1:0]  ack_num,
    output vec_t                  grp_q,
    output vec_t                  pend_q,
    output vec_t                  fan_q,
    output vec_t                  mask_q  [NCPU],
    output vec_t                  force_q [NCPU],
    output logic [EXTW-1:0]       ext_q   [NCPU]
);
    logic [1:0]      wbank;
    logic [IDXW-1:0] widx;
    vec_t            wlow;
    vec_t            whigh;
    vec_t            irq_eff;
    vec_t            ack_any;
    vec_t            pend_n;
    vec_t            ack_bits [NCPU];
    vec_t            force_n  [NCPU];

    assign wbank   = wr_word[WORDW-1:WORDW-2];
    assign widx    = wr_word[IDXW-1:0];
    assign wlow    = wr_data[15:0] & LINE_MASK;
    assign whigh   = wr_data[31:16] & LINE_MASK;
    assign irq_eff = irq_in & LINE_MASK;

    // decode each CPU's acknowledge number into a one-hot line vector
    always_comb begin
        ack_any = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (ack_vld[c]) begin
                ack_bits[c] = (vec_t'(1) << ack_num[c*LVLW +: LVLW]) & LINE_MASK;
            end else begin
                ack_bits[c] = '0;
            end
            ack_any = ack_any | ack_bits[c];
        end
    end

    // next pending: clear write, then acknowledges, then non-fanned pulses
    always_comb begin
        pend_n = pend_q;
        if (wr_en && wr_word == W_CLR) begin
            pend_n = pend_n & ~wlow;
        end
        pend_n = pend_n & ~ack_any;
        pend_n = pend_n | (irq_eff & ~fan_q);
    end

    // next force per CPU: alias or set/clear write, own acknowledge, fanned pulses
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            force_n[c] = force_q[c];
            if (wr_en && c == 0 && wr_word == W_ALIAS) begin
                force_n[c] = wlow;
            end
            if (wr_en && wbank == BANK_FORCE && widx == IDXW'(c)) begin
                force_n[c] = (force_n[c] | wlow) & ~whigh;
            end
            force_n[c] = force_n[c] & ~ack_bits[c];
            force_n[c] = force_n[c] | (irq_eff & fan_q);
        end
    end

    // pending and force registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int c = 0; c < NCPU; c++) begin
                force_q[c] <= '0;
            end
        end else begin
            pend_q <= pend_n;
            for (int c = 0; c < NCPU; c++) begin
                force_q[c] <= force_n[c];
            end
        end
    end

    // group-select and fan-out registers, written whole by the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
            fan_q <= '0;
        end else if (wr_en) begin
            if (wr_word == W_GRP) begin
                grp_q <= wlow;
            end
            if (wr_word == W_FAN) begin
                fan_q <= wlow;
            end
        end
    end

    // per-CPU mask and extended words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++) begin
                mask_q[c] <= '0;
                ext_q[c]  <= '0;
            end
        end else if (wr_en) begin
            for (int c = 0; c < NCPU; c++) begin
                if (wbank == BANK_MASK && widx == IDXW'(c)) begin
                    mask_q[c] <= wlow;
                end
                if (wbank == BANK_EXT && widx == IDXW'(c)) begin
                    ext_q[c] <= wr_data[EXTW-1:0];
                end
            end
        end
    end

    // R12: a non-fanned pulse always leaves its pending bit set
    a_r12_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(irq_in) & ~$past(fan_q) & LINE_MASK) & ~pend_q) == '0));

    // R7: a pending bit only rises from a non-fanned pulse
    a_r7_pending_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~($past(irq_in) & ~$past(fan_q))) == '0));

    generate
        for (genvar g = 0; g < NCPU; g++) begin : g_force_chk
            // R7: without a bus write, force bits only rise from fanned pulses
            a_r7_force_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(wr_en)) |->
                ((force_q[g] & ~$past(force_q[g]) & ~($past(irq_in) & $past(fan_q))) == '0));
        end
    endgenerate
endmodule

// File: rtl/mpic_rdmux.sv
// Module: read decoder. Selects the register word addressed by rd_word.
// Returns zero for the clear and status words, unmapped words and words of
// CPUs beyond NCPU. Purely combinational.
module mpic_rdmux
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic [WORDW-1:0] rd_word,
    input  vec_t             grp_q,
    input  vec_t             pend_q,
    input  vec_t             fan_q,
    input  vec_t             mask_q  [NCPU],
    input  vec_t             force_q [NCPU],
    input  logic [EXTW-1:0]  ext_q   [NCPU],
    output logic [31:0]      rd_data
);
    logic [1:0]      rbank;
    logic [IDXW-1:0] ridx;

    assign rbank = rd_word[WORDW-1:WORDW-2];
    assign ridx  = rd_word[IDXW-1:0];

    // pick the addressed word, default zero
    always_comb begin
        rd_data = '0;
        case (rbank)
            BANK_GLOBAL: begin
                case (rd_word)
                    W_GRP:   rd_data = {16'h0, grp_q};
                    W_PEND:  rd_data = {16'h0, pend_q};
                    W_ALIAS: rd_data = {16'h0, force_q[0]};
                    W_FAN:   rd_data = {16'h0, fan_q};
                    default: rd_data = '0;
                endcase
            end
            BANK_MASK: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (ridx == IDXW'(c)) rd_data = {16'h0, mask_q[c]};
                end
            end
            BANK_FORCE: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (ridx == IDXW'(c)) rd_data = {16'h0, force_q[c]};
                end
            end
            default: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (ridx == IDXW'(c)) rd_data = {{(32-EXTW){1'b0}}, ext_q[c]};
                end
            end
        endcase
    end
endmodule

// File: rtl/mpic_prio.sv
// Module: per-CPU priority encoder. Forms the CPU's active set and serves the
// high group when it has any line, otherwise the low group. Outputs the
// highest line number of the served group, or 0. Combinational; the clock
// and reset only feed the assertions.
module mpic_prio
    import mpic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  vec_t            pend,
    input  vec_t            force_v,
    input  vec_t            mask_v,
    input  vec_t            grp,
    output logic [LVLW-1:0] lvl
);
    vec_t active;
    vec_t hi_set;
    vec_t sel;

    // active set and group split
    always_comb begin
        active = (pend | force_v) & mask_v & LINE_MASK;
        hi_set = active & grp;
        sel    = (hi_set != '0) ? hi_set : (active & ~grp);
    end

    // highest set line of the served group
    always_comb begin
        lvl = '0;
        for (int i = 1; i < LINES; i++) begin
            if (sel[i]) lvl = LVLW'(i);
        end
    end

    // R3: no active line gives level 0
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (lvl == '0));

    // R3: a non-zero level names an active line
    a_r3_level_is_active: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != '0) |-> active[lvl]);

    // R3: any active high-group line means the level is in the high group
    a_r3_high_group_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((active & grp) != '0) |-> grp[lvl]);
endmodule

// File: rtl/mpic_top.sv
// Module: top of the interrupt controller. Ties the register state, the read
// decoder and one priority encoder per CPU together. Assumes word-aligned
// addresses; address bits 1:0 are ignored.
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            reg_addr,
    input  logic                  reg_we,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [LINES-1:0]      irq_pulse,
    input  logic [NCPU-1:0]       ack_valid,
    input  logic [NCPU*LVLW-1:0]  ack_line,
    output logic [NCPU*LVLW-1:0]  cpu_level
);
    logic [WORDW-1:0] word;
    vec_t             grp_q;
    vec_t             pend_q;
    vec_t             fan_q;
    vec_t             mask_q  [NCPU];
    vec_t             force_q [NCPU];
    logic [EXTW-1:0]  ext_q   [NCPU];

    assign word = reg_addr[7:2];

    mpic_regs #(.NCPU(NCPU)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_word (word),
        .wr_data (reg_wdata),
        .irq_in  (irq_pulse),
        .ack_vld (ack_valid),
        .ack_num (ack_line),
        .grp_q   (grp_q),
        .pend_q  (pend_q),
        .fan_q   (fan_q),
        .mask_q  (mask_q),
        .force_q (force_q),
        .ext_q   (ext_q)
    );

    mpic_rdmux #(.NCPU(NCPU)) u_rdmux (
        .rd_word (word),
        .grp_q   (grp_q),
        .pend_q  (pend_q),
        .fan_q   (fan_q),
        .mask_q  (mask_q),
        .force_q (force_q),
        .ext_q   (ext_q),
        .rd_data (reg_rdata)
    );

    generate
        for (genvar g = 0; g < NCPU; g++) begin : g_cpu
            mpic_prio u_prio (
                .clk     (clk),
                .rst_n   (rst_n),
                .pend    (pend_q),
                .force_v (force_q[g]),
                .mask_v  (mask_q[g]),
                .grp     (grp_q),
                .lvl     (cpu_level[g*LVLW +: LVLW])
            );
        end
    endgenerate
endmodule

// File: tb/mpic_top_test.sv
// Bench: two-CPU build. An arithmetic model follows each bus, pulse and
// acknowledge cycle; levels and the whole register map are compared to it.
module mpic_top_test;
    localparam int NC = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [15:0]     irq_pulse = '0;
    logic [NC-1:0]   ack_valid = '0;
    logic [NC*4-1:0] ack_line = '0;
    logic [NC*4-1:0] cpu_level;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] m_grp, m_pend, m_fan;
    logic [15:0] m_mask [NC];
    logic [15:0] m_force [NC];
    logic [3:0]  m_ext [NC];
    logic [31:0] seed = 32'h1234_5678;

    mpic_top #(.NCPU(NC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
        .ack_valid(ack_valid), .ack_line(ack_line), .cpu_level(cpu_level)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] model_read(input int w);
        logic [31:0] r = '0;
        if (w == 0) r = {16'h0, m_grp};
        else if (w == 1) r = {16'h0, m_pend};
        else if (w == 2) r = {16'h0, m_force[0]};
        else if (w == 5) r = {16'h0, m_fan};
        else if (w >= 16 && w < 16 + NC) r = {16'h0, m_mask[w-16]};
        else if (w >= 32 && w < 32 + NC) r = {16'h0, m_force[w-32]};
        else if (w >= 48 && w < 48 + NC) r = {28'h0, m_ext[w-48]};
        return r;
    endfunction

    function automatic logic [3:0] model_level(input int c);
        logic [15:0] act, s;
        logic [3:0]  l = '0;
        act = (m_pend | m_force[c]) & m_mask[c] & 16'hFFFE;
        s = ((act & m_grp) != 0) ? (act & m_grp) : (act & ~m_grp);
        for (int i = 1; i < 16; i++) if (s[i]) l = 4'(i);
        return l;
    endfunction

    // one cycle of stimulus; the model applies the same cycle's rules
    task automatic op(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] irq, input logic [NC-1:0] av,
                      input logic [NC*4-1:0] an);
        logic [15:0] irqe, np, lo, hi, anyack;
        logic [15:0] ab [NC];
        logic [15:0] nf [NC];
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        irq_pulse = irq; ack_valid = av; ack_line = an;
        irqe = irq & 16'hFFFE; lo = d[15:0] & 16'hFFFE; hi = d[31:16] & 16'hFFFE;
        anyack = '0;
        for (int c = 0; c < NC; c++) begin
            ab[c] = av[c] ? ((16'h1 << an[c*4 +: 4]) & 16'hFFFE) : 16'h0;
            anyack |= ab[c];
        end
        np = m_pend;
        if (we && a == 8'h0C) np &= ~lo;
        np = (np & ~anyack) | (irqe & ~m_fan);
        for (int c = 0; c < NC; c++) begin
            nf[c] = m_force[c];
            if (we && c == 0 && a == 8'h08) nf[c] = lo;
            if (we && a == 8'(8'h80 + 4*c)) nf[c] = (nf[c] | lo) & ~hi;
            nf[c] = (nf[c] & ~ab[c]) | (irqe & m_fan);
        end
        @(posedge clk);
        m_pend = np;
        for (int c = 0; c < NC; c++) m_force[c] = nf[c];
        if (we) begin
            if (a == 8'h00) m_grp = lo;
            if (a == 8'h14) m_fan = lo;
            for (int c = 0; c < NC; c++) begin
                if (a == 8'(8'h40 + 4*c)) m_mask[c] = lo;
                if (a == 8'(8'hC0 + 4*c)) m_ext[c] = d[3:0];
            end
        end
        #1;
        reg_we = 1'b0; irq_pulse = '0; ack_valid = '0; ack_line = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1'b1, a, d, 16'h0, '0, '0);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic levels_chk(input string tag);
        @(negedge clk);
        #1;
        for (int c = 0; c < NC; c++)
            chk({28'h0, cpu_level[c*4 +: 4]}, {28'h0, model_level(c)}, tag);
    endtask

    task automatic map_chk(input string tag);
        for (int w = 0; w < 64; w++) rd_chk(8'(w*4), model_read(w), tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_grp = '0; m_pend = '0; m_fan = '0;
        for (int c = 0; c < NC; c++) begin m_mask[c] = '0; m_force[c] = '0; m_ext[c] = '0; end
        irq_pulse = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        irq_pulse = '0;

        // R1 reset state
        map_chk("R1 reset map");
        levels_chk("R1 reset level");

        // R2 bit 0 and upper half never stored
        wr(8'h00, 32'hFFFF_FFFF); rd_chk(8'h00, 32'h0000_FFFE, "R2 group");
        wr(8'h14, 32'hFFFF_FFFF); rd_chk(8'h14, 32'h0000_FFFE, "R2 fanout");
        wr(8'h44, 32'hFFFF_FFFF); rd_chk(8'h44, 32'h0000_FFFE, "R2 mask");
        wr(8'h80, 32'h0000_FFFF); rd_chk(8'h80, 32'h0000_FFFE, "R2 force");
        // R10 extended low four bits
        wr(8'hC4, 32'hFFFF_FFFF); rd_chk(8'hC4, 32'h0000_000F, "R10 ext");
        // R9 status ignores writes
        wr(8'h10, 32'hFFFF_FFFF); rd_chk(8'h10, 32'h0, "R9 status");
        // R11 missing CPUs and unmapped words
        wr(8'h48, 32'hFFFF); wr(8'h88, 32'hFFFF); wr(8'hC8, 32'hF); wr(8'h20, 32'hFFFF);
        map_chk("R11 R13 map after odd writes");
        // R5 clear does nothing to zero pending, reads zero
        wr(8'h0C, 32'hFFFF_FFFF); rd_chk(8'h0C, 32'h0, "R5 clear reads zero");
        // reset registers to a known mix
        wr(8'h00, 32'h0); wr(8'h14, 32'h0); wr(8'h80, 32'hFFFE_0000);
        wr(8'h40, 32'hFFFE); wr(8'h44, 32'hFFFE);

        // R7 non-fanned pulse to pending
        op(1'b0, 8'h0, 32'h0, 16'h0049, '0, '0);
        rd_chk(8'h04, 32'h0000_0048, "R7 pending pulse");
        levels_chk("R3 low group only");
        // R5 clear removes lines
        wr(8'h0C, 32'h0000_0041); rd_chk(8'h04, 32'h0000_0008, "R5 clear lines");
        // R7 fanned pulse goes to every force, not pending
        wr(8'h14, 32'h0000_0020);
        op(1'b0, 8'h0, 32'h0, 16'h0060, '0, '0);
        rd_chk(8'h80, 32'h0000_0020, "R7 fan cpu0");
        rd_chk(8'h84, 32'h0000_0020, "R7 fan cpu1");
        rd_chk(8'h04, 32'h0000_0048, "R7 fan pending");
        // R3 high group served first
        wr(8'h00, 32'h0000_0020); levels_chk("R3 high group");
        // R8 acknowledge by CPU1 of line 5
        op(1'b0, 8'h0, 32'h0, 16'h0, 2'b10, 8'h50);
        rd_chk(8'h84, 32'h0, "R8 ack own force");
        rd_chk(8'h80, 32'h0000_0020, "R8 ack other force");
        // R8 acknowledge of line 0 has no effect
        op(1'b0, 8'h0, 32'h0, 16'h0, 2'b01, 8'h00);
        map_chk("R8 ack line 0");
        op(1'b0, 8'h0, 32'h0, 16'h0, 2'b01, 8'h06);
        rd_chk(8'h04, 32'h0000_0008, "R8 ack pending");
        // R4 set and clear in one write, overlap clears
        wr(8'h84, 32'h0030_00F0); rd_chk(8'h84, 32'h0000_00C0, "R4 set clear");
        wr(8'h84, 32'h0040_0100); rd_chk(8'h84, 32'h0000_0180, "R4 keep old");
        // R6 alias overwrites CPU0 force
        wr(8'h08, 32'h0000_0301); rd_chk(8'h80, 32'h0000_0300, "R6 alias");
        rd_chk(8'h08, 32'h0000_0300, "R6 alias read");
        // R12 pulse versus clear and acknowledge on the same line
        wr(8'h14, 32'h0);
        op(1'b1, 8'h0C, 32'h0000_0200, 16'h0200, '0, '0);
        rd_chk(8'h04, 32'h0000_0208, "R12 pulse beats clear");
        op(1'b0, 8'h0, 32'h0, 16'h0200, 2'b11, 8'h99);
        rd_chk(8'h04, 32'h0000_0208, "R12 pulse beats ack");
        map_chk("R12 map");

        // R3 sweep over random traffic
        for (int t = 0; t < 160; t++) begin
            wr(8'h00, rnd());
            wr(8'h40, rnd());
            wr(8'h44, rnd());
            wr(8'h14, rnd() & 32'h0000_3C3C);
            wr(8'h08, rnd());
            wr(8'h84, rnd());
            op(1'b0, 8'h0, 32'h0, 16'(rnd()), '0, '0);
            levels_chk("R3 sweep");
            op(1'b0, 8'h0, 32'h0, 16'(rnd()), 2'(rnd()), 8'(rnd()));
            levels_chk("R3 R8 sweep ack");
            if (t % 16 == 0) map_chk("R3 sweep map");
            wr(8'h0C, 32'hFFFF);
            wr(8'h80, 32'hFFFE_0000);
            wr(8'h84, 32'hFFFE_0000);
            levels_chk("R3 sweep cleared");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule